// File: doc/BRIEF.md
# Register-Mapped Serial Port with Flagged Receive Words

This block is a UART peripheral seen by software as five 32-bit word registers: a control word, a baud word, a FIFO-configuration word, a status word and a data port. Software writes bytes to the data port. A transmit FIFO queues them, and a serializer sends each one as an asynchronous frame. A deserializer samples the receive line sixteen times per bit. Each received byte is stored in a receive FIFO together with three error flags, so a single read of the data port returns the byte and the conditions under which it arrived.

One baud generator sets the bit timing for both directions. It has its own enable, separate from the transmitter and receiver enables. The control word also selects the symbol size, the stop length, parity per direction, a forced break and an internal loopback from the transmit line to the receiver. Two control bits empty the FIFOs and then clear themselves. The status word reports when transmission has drained, when receive data is waiting, and when a receive overrun has occurred.

Top module: `uart_regfifo`

## Requirements
- R1: After reset the control word reads 0x00003705, the FIFO-configuration word (offset 0x08) reads 0x00004400, the baud word (offset 0x04) reads 0, the status word (offset 0x10) reads 0x20 (bit 5, transmit side drained), and `txd` is high.
- R2: A write to offset 0x14 queues a byte. With control bit 22 and bit 23 set, the byte goes out on `txd` as one low start bit, then the data bits least significant first, then a high stop bit.
- R3: The baud word B is held at offset 0x04. A bit lasts 32*(B+1) clock cycles, because a sample tick comes every 2*(B+1) cycles and a bit is sixteen ticks. When control bit 23 is clear there are no ticks and nothing moves on either line.
- R4: Control bit 19 adds a transmit parity bit after the data bits. Bit 18 selects even parity (the parity bit equals the XOR of the data bits) or, when clear, odd parity.
- R5: Control bit 20 feeds the transmit line to the receiver. A received word is read at offset 0x14 with the byte in bits [7:0], and status bit 11 is set while the receive FIFO holds data.
- R6: Writing control bit 6 empties the receive FIFO and writing bit 7 empties the transmit FIFO. Both bits read back as 0 on the next read.
- R7: A received frame whose stop sample is low sets bit 8 (framing) of its data-port word. If its data bits are also all low, bit 10 (break) is set as well.
- R8: A byte that completes while the receive FIFO is full is dropped and sets status bit 7. That bit stays set until the receive FIFO is reset or a status write has bit 7 at 0.
- R9: Clearing control bit 22 halts the transmitter with `txd` high and queued bytes kept. Clearing control bit 21 makes the receiver ignore the line.
- R10: Control bit 14 drives `txd` low for as long as it is set.
- R11: Control bits [13:12] hold a code c that gives c+5 data bits. Bits [11:8] hold a code s that gives a stop length of s+9 ticks (code 7 is one bit). Back-to-back frames start (16*(1+data bits)+s+9) ticks apart.
- R12: Control bit 17 makes the receiver expect a parity bit, and bit 16 selects even parity. A mismatch sets bit 9 of the data-port word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte offset of the word register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read at 0x14 pops the receive FIFO |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The overrun case is the hardest condition to reach from the ports. The receive FIFO must be full, and one more complete frame must then arrive before software reads anything. The bench drives seventeen frames back to back on `rxd` without reading the data port. It then confirms that the first byte queued is still at the head, and that the overrun flag clears independently of the waiting data. Break and framing words are reached by driving frames with a low stop bit, which requires the receiver to rearm only on a fresh high-to-low edge.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
  localparam logic [4:0] OFF_CTL  = 5'h00;
  localparam logic [4:0] OFF_BAUD = 5'h04;
  localparam logic [4:0] OFF_FCFG = 5'h08;
  localparam logic [4:0] OFF_STAT = 5'h10;
  localparam logic [4:0] OFF_DATA = 5'h14;

  localparam int CB_RXRST = 6;
  localparam int CB_TXRST = 7;
  localparam int CB_BRK   = 14;
  localparam int CB_RXEVN = 16;
  localparam int CB_RXPAR = 17;
  localparam int CB_TXEVN = 18;
  localparam int CB_TXPAR = 19;
  localparam int CB_LOOP  = 20;
  localparam int CB_RXEN  = 21;
  localparam int CB_TXEN  = 22;
  localparam int CB_BRGEN = 23;

  localparam logic [31:0] CTL_RESET  = 32'h0000_3705;
  localparam logic [31:0] CTL_WMASK  = 32'h00FF_7F1F;
  localparam logic [31:0] FCFG_RESET = 32'h0000_4400;
  localparam logic [31:0] FCFG_WMASK = 32'h0000_FF00;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_state_t;

  // number of data bits for a symbol-size code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // stop length in sample ticks for a stop code
  function automatic logic [4:0] stop_ticks(input logic [3:0] code);
    return 5'd9 + {1'b0, code};
  endfunction

  function automatic logic [7:0] data_mask(input logic [3:0] nbits);
    return 8'hFF >> (4'd8 - nbits);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction
endpackage

// File: rtl/uart_baud.sv
`timescale 1ns/1ps
module uart_baud #(
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [BW-1:0] word,
  output logic          tick
);
  logic [BW:0] cnt_q;
  logic [BW:0] lim;

  assign lim  = {word, 1'b1};
  assign tick = en && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_fifo.sv
`timescale 1ns/1ps
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (flush) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) wp_q <= wp_q + 1'b1;
      if (pop && !empty) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
module uart_tx
  import uart_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic [3:0] nbits,
  input  logic [4:0] stop_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       brk,
  input  logic       have,
  input  logic [7:0] din,
  output logic       pop,
  output logic       busy,
  output logic       txd
);
  ser_state_t st_q;
  logic [4:0] cnt_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic       par_q, line, stop_end, bit_end;
  logic [7:0] masked;

  assign masked   = din & data_mask(nbits);
  assign bit_end  = (cnt_q == 5'd15);
  assign stop_end = (cnt_q == stop_len - 5'd1);
  assign pop      = en && tick && have && (st_q == S_IDLE || (st_q == S_STOP && stop_end));
  assign busy     = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0; par_q <= 1'b0;
    end else if (!en) begin
      st_q <= S_IDLE; cnt_q <= '0;
    end else if (pop) begin
      st_q  <= S_START; cnt_q <= '0; idx_q <= '0;
      sh_q  <= masked;
      par_q <= par_bit(masked, par_even);
    end else if (tick) begin
      cnt_q <= cnt_q + 5'd1;
      unique case (st_q)
        S_START: if (bit_end) begin st_q <= S_DATA; cnt_q <= '0; end
        S_DATA: if (bit_end) begin
          cnt_q <= '0;
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'(nbits - 4'd1)) st_q <= par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (bit_end) begin st_q <= S_STOP; cnt_q <= '0; end
        S_STOP: if (stop_end) begin st_q <= S_IDLE; cnt_q <= '0; end
        default: cnt_q <= '0;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: line = 1'b0;
      S_DATA:  line = sh_q[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
  end

  assign txd = brk ? 1'b0 : line;
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx
  import uart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        tick,
  input  logic        line,
  input  logic [3:0]  nbits,
  input  logic        par_en,
  input  logic        par_even,
  output logic        push,
  output logic [10:0] word
);
  ser_state_t st_q;
  logic [1:0] sync_q;
  logic       rx_s, prev_q, pbit_q, mid, bit_end;
  logic [4:0] cnt_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q, data;
  logic       ferr, perr, brk;

  assign rx_s    = sync_q[1];
  assign mid     = (cnt_q == 5'd7);
  assign bit_end = (cnt_q == 5'd15);
  assign data    = sh_q >> (4'd8 - nbits);
  assign ferr    = !rx_s;
  assign brk     = ferr && (data == 8'h00);
  assign perr    = par_en && (pbit_q != par_bit(data, par_even));
  assign push    = en && tick && (st_q == S_STOP) && bit_end;
  assign word    = {brk, perr, ferr, data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11; prev_q <= 1'b1; st_q <= S_IDLE;
      cnt_q <= '0; idx_q <= '0; sh_q <= '0; pbit_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line};
      if (!en) begin
        st_q <= S_IDLE; cnt_q <= '0; prev_q <= 1'b1;
      end else if (tick) begin
        prev_q <= rx_s;
        cnt_q  <= cnt_q + 5'd1;
        unique case (st_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (prev_q && !rx_s) st_q <= S_START;
          end
          S_START: if (mid) begin
            cnt_q <= '0; idx_q <= '0;
            st_q  <= rx_s ? S_IDLE : S_DATA;
          end
          S_DATA: if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[7:1]};
            idx_q <= idx_q + 3'd1;
            if (idx_q == 3'(nbits - 4'd1)) st_q <= par_en ? S_PAR : S_STOP;
          end
          S_PAR: if (bit_end) begin cnt_q <= '0; pbit_q <= rx_s; st_q <= S_STOP; end
          default: if (bit_end) begin cnt_q <= '0; st_q <= S_IDLE; end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regfifo.sv
`timescale 1ns/1ps
module uart_regfifo
  import uart_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BAUD_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd
);
  localparam int RXW = 11;

  logic [31:0]       ctl_q, fcfg_q;
  logic [BAUD_W-1:0] baud_q;
  logic [1:0]        rst_pulse_q;
  logic              ovr_q;

  logic ctl_wr, baud_wr, fcfg_wr, stat_wr, data_wr, data_rd;
  assign ctl_wr  = bus_wr && (bus_addr == OFF_CTL);
  assign baud_wr = bus_wr && (bus_addr == OFF_BAUD);
  assign fcfg_wr = bus_wr && (bus_addr == OFF_FCFG);
  assign stat_wr = bus_wr && (bus_addr == OFF_STAT);
  assign data_wr = bus_wr && (bus_addr == OFF_DATA);
  assign data_rd = bus_rd && (bus_addr == OFF_DATA);

  logic brg_en, tx_en, rx_en, rx_flush, tx_flush, tick;
  logic [3:0] nbits;
  logic [4:0] stop_len;
  assign brg_en   = ctl_q[CB_BRGEN];
  assign tx_en    = ctl_q[CB_TXEN];
  assign rx_en    = ctl_q[CB_RXEN];
  assign rx_flush = rst_pulse_q[0];
  assign tx_flush = rst_pulse_q[1];
  assign nbits    = data_bits(ctl_q[13:12]);
  assign stop_len = stop_ticks(ctl_q[11:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET; fcfg_q <= FCFG_RESET; baud_q <= '0; rst_pulse_q <= 2'b00;
    end else begin
      rst_pulse_q <= ctl_wr ? {bus_wdata[CB_TXRST], bus_wdata[CB_RXRST]} : 2'b00;
      if (ctl_wr)  ctl_q  <= bus_wdata & CTL_WMASK;
      if (fcfg_wr) fcfg_q <= bus_wdata & FCFG_WMASK;
      if (baud_wr) baud_q <= bus_wdata[BAUD_W-1:0];
    end
  end

  uart_baud #(.BW(BAUD_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .en(brg_en), .word(baud_q), .tick(tick));

  // transmit path
  logic [7:0] tx_head;
  logic tx_empty, tx_full, tx_pop, tx_busy, tx_line;
  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(data_wr), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  uart_tx i_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick), .nbits(nbits), .stop_len(stop_len),
    .par_en(ctl_q[CB_TXPAR]), .par_even(ctl_q[CB_TXEVN]), .brk(ctl_q[CB_BRK]),
    .have(!tx_empty), .din(tx_head), .pop(tx_pop), .busy(tx_busy), .txd(tx_line));
  assign txd = tx_line;

  // receive path
  logic [RXW-1:0] rx_word, rx_head;
  logic rx_push, rx_empty, rx_full, rx_in;
  assign rx_in = ctl_q[CB_LOOP] ? tx_line : rxd;

  uart_rx i_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line(rx_in), .nbits(nbits),
    .par_en(ctl_q[CB_RXPAR]), .par_even(ctl_q[CB_RXEVN]), .push(rx_push), .word(rx_word));

  uart_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push && !rx_full), .din(rx_word),
    .pop(data_rd), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ovr_q <= 1'b0;
    else if (rx_flush)            ovr_q <= 1'b0;
    else if (rx_push && rx_full)  ovr_q <= 1'b1;
    else if (stat_wr && !bus_wdata[7]) ovr_q <= 1'b0;
  end

  logic [31:0] stat;
  always_comb begin
    stat = '0;
    stat[5]  = tx_empty && !tx_busy;
    stat[7]  = ovr_q;
    stat[11] = !rx_empty;
  end

  always_comb begin
    unique case (bus_addr)
      OFF_CTL:  bus_rdata = ctl_q | {24'b0, rst_pulse_q, 6'b0};
      OFF_BAUD: bus_rdata = {{(32-BAUD_W){1'b0}}, baud_q};
      OFF_FCFG: bus_rdata = fcfg_q;
      OFF_STAT: bus_rdata = stat;
      OFF_DATA: bus_rdata = rx_empty ? 32'h0 : {{(32-RXW){1'b0}}, rx_head};
      default:  bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/uart_regfifo_chk.sv
`timescale 1ns/1ps
module uart_regfifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        brg_en,
  input logic        tx_en,
  input logic        tx_busy,
  input logic        ctl_wr,
  input logic [1:0]  rst_pulse_q,
  input logic        rx_flush,
  input logic        rx_empty,
  input logic        rx_push,
  input logic        rx_full,
  input logic        ovr_q,
  input logic [10:0] rx_word
);
  assert_no_tick_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !brg_en |=> !tick);
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_empty);
  assert_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse_q != 2'b00 && !ctl_wr) |=> (rst_pulse_q == 2'b00));
  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_flush) |=> ovr_q);
  assert_break_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_word[10]) |-> rx_word[8]);
  assert_tx_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_busy);
endmodule

bind uart_regfifo uart_regfifo_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .brg_en(brg_en), .tx_en(tx_en),
  .tx_busy(tx_busy), .ctl_wr(ctl_wr), .rst_pulse_q(rst_pulse_q), .rx_flush(rx_flush),
  .rx_empty(rx_empty), .rx_push(rx_push), .rx_full(rx_full), .ovr_q(ovr_q),
  .rx_word(rx_word));

// File: tb/test_uart_regfifo.sv
`timescale 1ns/1ps
module test_uart_regfifo;
  localparam int BIT = 64;          // baud word 1 -> 32*(1+1) cycles per bit
  localparam logic [31:0] EN = 32'h00E0_3705;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, rxd = 1;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic txd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regfifo i_uart_regfifo (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  // captures n bits after the start bit, sampled mid-bit
  task automatic cap_tx(int n, output logic [15:0] bits);
    bits = '0;
    while (txd !== 1'b0) @(negedge clk);
    idle(BIT/2);
    for (int i = 0; i < n; i++) begin idle(BIT); bits[i] = txd; end
  endtask

  task automatic send_rx(logic [7:0] d, int nb, bit has_par, bit pbit, bit stopv);
    @(negedge clk); rxd = 0; idle(BIT);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; idle(BIT); end
    if (has_par) begin rxd = pbit; idle(BIT); end
    rxd = stopv; idle(BIT);
    rxd = 1; idle(BIT);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 txd", {31'b0, txd}, 32'h1);
    rd(5'h00, v); check("R1 ctl", v, 32'h0000_3705);
    rd(5'h08, v); check("R1 fcfg", v, 32'h0000_4400);
    rd(5'h04, v); check("R1 baud", v, 32'h0);
    rd(5'h10, v); check("R1 status", v, 32'h20);
  endtask

  task automatic t_tx_frame;
    logic [15:0] b; logic [31:0] v; int w;
    wr(5'h04, 32'h1); rd(5'h04, v); check("R3 baud readback", v, 32'h1);
    wr(5'h00, EN);
    wr(5'h14, 32'hA5); cap_tx(9, b);
    check("R2 data bits", {24'b0, b[7:0]}, 32'hA5);
    check("R2 stop bit", {31'b0, b[8]}, 32'h1);
    idle(2*BIT);
    wr(5'h14, 32'hA5);
    while (txd !== 1'b0) @(negedge clk);
    w = 0; while (txd === 1'b0) begin @(negedge clk); w++; end
    check("R3 bit time", w, BIT);
    idle(10*BIT);
    rd(5'h10, v); check("R2 drained", v & 32'h20, 32'h20);
  endtask

  task automatic t_tx_parity;
    logic [15:0] b;
    wr(5'h00, EN | 32'h000C_0000); wr(5'h14, 32'h07); cap_tx(10, b);
    check("R4 even parity", {30'b0, b[9:8]}, 32'h3);
    idle(2*BIT);
    wr(5'h00, EN | 32'h0008_0000); wr(5'h14, 32'h07); cap_tx(10, b);
    check("R4 odd parity", {30'b0, b[9:8]}, 32'h2);
    idle(2*BIT);
    wr(5'h00, EN);
  endtask

  task automatic t_loop;
    logic [31:0] v;
    wr(5'h00, EN | 32'h0010_0000); wr(5'h14, 32'h3C); idle(12*BIT);
    rd(5'h10, v); check("R5 rx not empty", v & 32'h800, 32'h800);
    rd(5'h14, v); check("R5 loopback data", v, 32'h3C);
    rd(5'h10, v); check("R5 drained rx", v & 32'h800, 32'h0);
    wr(5'h00, 32'h00F0_2705); wr(5'h14, 32'hFF); idle(12*BIT);
    rd(5'h14, v); check("R11 seven data bits", v, 32'h7F);
    wr(5'h00, EN);
  endtask

  task automatic t_stop_len;
    int cnt;
    wr(5'h00, 32'h00E0_3F05);
    wr(5'h14, 32'hFF); wr(5'h14, 32'hFF);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0;
    while (txd !== 1'b1) begin @(negedge clk); cnt++; end
    while (txd !== 1'b0) begin @(negedge clk); cnt++; end
    check("R11 frame spacing", cnt, (16*9 + 24) * 4);
    idle(12*BIT);
    wr(5'h00, EN);
  endtask

  task automatic t_rx_flags;
    logic [31:0] v;
    send_rx(8'h55, 8, 0, 0, 0); rd(5'h14, v); check("R7 framing", v, 32'h155);
    send_rx(8'h00, 8, 0, 0, 0); rd(5'h14, v); check("R7 break", v, 32'h500);
    send_rx(8'h5A, 8, 0, 0, 1); rd(5'h14, v); check("R7 clean", v, 32'h5A);
    wr(5'h00, EN | 32'h0003_0000);
    send_rx(8'h01, 8, 1, 0, 1); rd(5'h14, v); check("R12 parity error", v, 32'h201);
    send_rx(8'h01, 8, 1, 1, 1); rd(5'h14, v); check("R12 parity ok", v, 32'h001);
    wr(5'h00, EN);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    for (int i = 0; i < 17; i++) send_rx(8'(i + 8'h10), 8, 0, 0, 1);
    rd(5'h10, v); check("R8 overrun set", v & 32'h880, 32'h880);
    rd(5'h14, v); check("R8 head kept", v, 32'h10);
    wr(5'h10, 32'h0); rd(5'h10, v); check("R8 cleared by write", v & 32'h880, 32'h800);
    wr(5'h00, EN | 32'h40); idle(2);
    rd(5'h10, v); check("R6 rx flush", v & 32'h880, 32'h0);
    rd(5'h00, v); check("R6 self clear", v & 32'hC0, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] v; bit low;
    wr(5'h00, 32'h0060_3705);           // brg off
    wr(5'h14, 32'h00);
    low = 0; for (int i = 0; i < 12*BIT; i++) begin @(negedge clk); if (txd === 1'b0) low = 1; end
    check("R3 no ticks", {31'b0, low}, 32'h0);
    wr(5'h00, 32'h00A0_3705);           // tx off
    low = 0; for (int i = 0; i < 12*BIT; i++) begin @(negedge clk); if (txd === 1'b0) low = 1; end
    check("R9 tx halted", {31'b0, low}, 32'h0);
    rd(5'h10, v); check("R9 byte kept", v & 32'h20, 32'h0);
    wr(5'h00, 32'h00A0_3785); idle(2);
    rd(5'h10, v); check("R6 tx flush", v & 32'h20, 32'h20);
    wr(5'h00, 32'h00C0_3705);           // rx off
    send_rx(8'h33, 8, 0, 0, 1);
    rd(5'h10, v); check("R9 rx ignored", v & 32'h800, 32'h0);
    wr(5'h00, EN);
  endtask

  task automatic t_break;
    wr(5'h00, EN | 32'h4000); idle(2);
    check("R10 break low", {31'b0, txd}, 32'h0);
    wr(5'h00, EN); idle(2);
    check("R10 break released", {31'b0, txd}, 32'h1);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset(); t_tx_frame(); t_tx_parity(); t_loop(); t_stop_len();
    t_rx_flags(); t_overrun(); t_disable(); t_break();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule